// File: doc/BRIEF.md
# Block Checksum Framer

This block sits in the byte stream of a point-to-point link. It protects the data with a short checksum that repeats through the transfer. In transmit mode it forwards the data bytes from its input stream to its output stream. After every block of N data bytes it adds one extra byte that carries the checksum of that block. In receive mode it takes the link stream, forwards the data bytes, and removes each checksum byte after comparing it with the sum it has built for that block.

A transfer begins with a one-cycle `start` pulse. The pulse loads the direction, the checksum enable, a four-bit block length code and the total number of data bytes. The length code is thermometer-style, and each extra low-order one halves the block length. A checksum mismatch on receive stops the transfer. The block then raises a level for the peer and a sticky status bit, and it holds the number of data bytes that were still outstanding.

Top module: `ckf_top`

## Requirements
- R1: With `ck_en` low at start, every data byte passes unchanged in both modes, no byte is inserted or removed, and `len_code` has no effect.
- R2: With `ck_en` high, `len_code` selects N as follows: 4'b0000 gives 32, 4'b0001 gives 16, 4'b0011 gives 8, 4'b0111 gives 4 and 4'b1111 gives 2.
- R3: In transmit mode with `ck_en` high, one checksum byte follows every N data bytes. Its value is the modulo-256 sum of the data bytes of that block, and the sum restarts at zero for each block.
- R4: When `byte_total` ends part-way through a block, a checksum byte covering the bytes of that partial block still follows them.
- R5: `byte_total` counts data bytes only. `done` pulses for one cycle in the cycle after the last data byte or last checksum byte is transferred. A start with `byte_total` of zero gives that pulse in the cycle after start, and no byte moves.
- R6: A start with `ck_en` high and any other length code, or a start with an odd `byte_total`, sets `cfg_err`. No transfer then begins: `busy`, `s_ready` and `m_valid` stay low. The next accepted start rewrites `cfg_err`.
- R7: In receive mode with `ck_en` high, the byte after each block is taken as a checksum. It is consumed without appearing at the output, and the data bytes appear unchanged.
- R8: When a received checksum differs from the computed one, `peer_err` rises in the next cycle and stays high until the next start. `ck_err_status` also rises and stays high until reset.
- R9: After a mismatch, `s_ready` stays low and `residual` holds `byte_total` minus the number of data bytes already forwarded. After a normal completion, `residual` is 0.
- R10: After reset, `busy`, `done`, `cfg_err`, `peer_err` and `ck_err_status` are low and `residual` is 0. While no transfer runs, `s_ready` and `m_valid` are low. During data bytes, backpressure on either side stalls the stream without losing or repeating a byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a transfer; accepted when no transfer runs |
| rx_mode | input | 1 | 1 = receive (check and strip), 0 = transmit (insert) |
| ck_en | input | 1 | Checksum enable for the transfer |
| len_code | input | 4 | Thermometer block length code |
| byte_total | input | CNT_W | Number of data bytes in the transfer |
| s_valid | input | 1 | Input stream byte valid |
| s_ready | output | 1 | Input stream byte accepted |
| s_data | input | DATA_W | Input stream byte |
| m_valid | output | 1 | Output stream byte valid |
| m_ready | input | 1 | Output stream sink ready |
| m_data | output | DATA_W | Output stream byte |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| cfg_err | output | 1 | Last start rejected for bad code or odd count |
| peer_err | output | 1 | Checksum error level toward the peer |
| ck_err_status | output | 1 | Sticky checksum error status |
| residual | output | CNT_W | Data bytes still outstanding |

## Verification
A wrong block position counter or a sum that fails to restart shows up at `m_data` as a wrong checksum byte, or a byte in the wrong place, at the end of the first block. That is within N+1 output transfers. A wrong remaining count shows up as a missing or extra partial-block checksum, a `done` pulse too early or too late, or a wrong `residual` after a halt. A sequencer that accepts input while halted or idle shows up through `s_ready` in the cycle the stimulus is applied. The bench therefore drives traffic with stalls on both sides, corrupts chosen checksum bytes, and samples every byte and flag in the cycle each one is due.

// File: rtl/ckf_pkg.sv
package ckf_pkg;
  localparam int CODE_W  = 4;
  localparam int MAX_BLK = 32;
  localparam int BLK_W   = $clog2(MAX_BLK + 1);

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_DATA = 2'd1,
    ST_CSUM = 2'd2,
    ST_HALT = 2'd3
  } ckf_state_e;

  // Thermometer code of w ones selects MAX_BLK >> w; anything else is 0 (invalid).
  function automatic logic [BLK_W-1:0] blk_len_of(input logic [CODE_W-1:0] code);
    logic [BLK_W-1:0] n;
    n = '0;
    for (int w = 0; w <= CODE_W; w++) begin
      if (code == CODE_W'((1 << w) - 1)) n = BLK_W'(MAX_BLK >> w);
    end
    return n;
  endfunction

  // A block closes on its N-th byte or on the last byte of the transfer.
  function automatic logic blk_close(input logic [BLK_W-1:0] pos,
                                     input logic [BLK_W-1:0] len,
                                     input logic             last);
    return (BLK_W'(pos + 1'b1) == len) || last;
  endfunction
endpackage

// File: rtl/ckf_cfg.sv
module ckf_cfg
  import ckf_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic              rx_in,
  input  logic              en_in,
  input  logic [CODE_W-1:0] code_in,
  input  logic              total_lsb,
  output logic              cfg_ok,
  output logic              rx_q,
  output logic              en_q,
  output logic [BLK_W-1:0]  blk_len_q
);
  logic [BLK_W-1:0] len_dec;

  always_comb begin
    len_dec = blk_len_of(code_in);
    cfg_ok  = !total_lsb && (!en_in || (len_dec != '0));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_q      <= 1'b0;
      en_q      <= 1'b0;
      blk_len_q <= '0;
    end else if (load) begin
      rx_q      <= rx_in;
      en_q      <= en_in;
      blk_len_q <= len_dec;
    end
  end
endmodule

// File: rtl/ckf_cnt.sv
module ckf_cnt
  import ckf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             dec,
  input  logic             blk_clr,
  input  logic [BLK_W-1:0] blk_len,
  output logic [CNT_W-1:0] remaining,
  output logic             last_data,
  output logic             blk_end
);
  logic [BLK_W-1:0] blk_pos;

  always_comb begin
    last_data = (remaining == CNT_W'(1));
    blk_end   = blk_close(blk_pos, blk_len, last_data);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      remaining <= '0;
      blk_pos   <= '0;
    end else begin
      if (load)     remaining <= load_val;
      else if (dec) remaining <= remaining - CNT_W'(1);
      if (load || blk_clr) blk_pos <= '0;
      else if (dec)        blk_pos <= BLK_W'(blk_pos + 1'b1);
    end
  end
endmodule

// File: rtl/ckf_acc.sv
module ckf_acc #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              add,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] sum
);
  always_ff @(posedge clk) begin
    if (!rst_n)   sum <= '0;
    else if (clr) sum <= '0;
    else if (add) sum <= sum + din;
  end
endmodule

// File: rtl/ckf_top.sv
module ckf_top
  import ckf_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              rx_mode,
  input  logic              ck_en,
  input  logic [CODE_W-1:0] len_code,
  input  logic [CNT_W-1:0]  byte_total,
  input  logic              s_valid,
  output logic              s_ready,
  input  logic [DATA_W-1:0] s_data,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic              busy,
  output logic              done,
  output logic              cfg_err,
  output logic              peer_err,
  output logic              ck_err_status,
  output logic [CNT_W-1:0]  residual
);
  ckf_state_e state_q, state_d;

  logic             cfg_ok, run_rx, run_en;
  logic [BLK_W-1:0] run_len;
  logic [CNT_W-1:0] remaining;
  logic             last_data, blk_end;
  logic [DATA_W-1:0] sum;

  // Named internal events (also observed by the checker).
  logic idle_like, accept, cfg_load, launch, empty_run;
  logic data_fire, csum_fire, mismatch, finish;

  always_comb begin
    idle_like = (state_q == ST_IDLE) || (state_q == ST_HALT);
    accept    = start && idle_like;
    cfg_load  = accept && cfg_ok;
    launch    = cfg_load && (byte_total != '0);
    empty_run = cfg_load && (byte_total == '0);
    data_fire = (state_q == ST_DATA) && s_valid && m_ready;
    csum_fire = (state_q == ST_CSUM) && (run_rx ? s_valid : m_ready);
    mismatch  = csum_fire && run_rx && (s_data != sum);
  end

  ckf_cfg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .rx_in     (rx_mode),
    .en_in     (ck_en),
    .code_in   (len_code),
    .total_lsb (byte_total[0]),
    .cfg_ok    (cfg_ok),
    .rx_q      (run_rx),
    .en_q      (run_en),
    .blk_len_q (run_len)
  );

  ckf_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (cfg_load),
    .load_val  (byte_total),
    .dec       (data_fire),
    .blk_clr   (csum_fire),
    .blk_len   (run_len),
    .remaining (remaining),
    .last_data (last_data),
    .blk_end   (blk_end)
  );

  ckf_acc #(.DATA_W(DATA_W)) u_acc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (cfg_load || csum_fire),
    .add   (data_fire),
    .din   (s_data),
    .sum   (sum)
  );

  always_comb begin
    state_d = state_q;
    finish  = 1'b0;
    unique case (state_q)
      ST_IDLE, ST_HALT: begin
        if (launch)      state_d = ST_DATA;
        else if (accept) state_d = ST_IDLE;
      end
      ST_DATA: begin
        if (data_fire) begin
          if (run_en && blk_end) begin
            state_d = ST_CSUM;
          end else if (last_data) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end
        end
      end
      ST_CSUM: begin
        if (csum_fire) begin
          if (mismatch) begin
            state_d = ST_HALT;
          end else if (remaining == '0) begin
            state_d = ST_IDLE;
            finish  = 1'b1;
          end else begin
            state_d = ST_DATA;
          end
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  logic done_q, cfg_err_q, stat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      done_q    <= 1'b0;
      cfg_err_q <= 1'b0;
      stat_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= finish || empty_run;
      if (accept)   cfg_err_q <= !cfg_ok;
      if (mismatch) stat_q    <= 1'b1;
    end
  end

  always_comb begin
    s_ready = 1'b0;
    m_valid = 1'b0;
    m_data  = s_data;
    if (state_q == ST_DATA) begin
      s_ready = m_ready;
      m_valid = s_valid;
    end else if (state_q == ST_CSUM) begin
      s_ready = run_rx;
      m_valid = !run_rx;
      m_data  = sum;
    end
  end

  assign busy          = (state_q == ST_DATA) || (state_q == ST_CSUM);
  assign done          = done_q;
  assign cfg_err       = cfg_err_q;
  assign peer_err      = (state_q == ST_HALT);
  assign ck_err_status = stat_q;
  assign residual      = remaining;
endmodule

// File: rtl/ckf_chk.sv
module ckf_chk
  import ckf_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             busy,
  input logic             s_ready,
  input logic             m_valid,
  input logic             done,
  input logic             cfg_err,
  input logic             peer_err,
  input logic             ck_err_status,
  input logic [CNT_W-1:0] residual,
  input logic             data_fire,
  input logic             csum_fire,
  input logic             mismatch,
  input logic             run_en
);
  localparam int CW = $clog2(MAX_BLK) + 2;
  logic [CW-1:0] blk_chk;

  // Data bytes seen since the last checksum byte of a checked transfer.
  always_ff @(posedge clk) begin
    if (!rst_n)                              blk_chk <= '0;
    else if (!run_en || csum_fire || start)  blk_chk <= '0;
    else if (data_fire && (blk_chk != '1))   blk_chk <= blk_chk + 1'b1;
  end

  assert_block_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    blk_chk <= CW'(MAX_BLK));

  assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!s_ready && !m_valid));

  assert_peer_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(peer_err) |-> $past(mismatch));

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ck_err_status |=> ck_err_status);

  assert_halt_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (peer_err && !start) |=> ($stable(residual) && !s_ready));

  assert_reject_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !busy);

  assert_done_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind ckf_top ckf_chk #(.CNT_W(CNT_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .start         (start),
  .busy          (busy),
  .s_ready       (s_ready),
  .m_valid       (m_valid),
  .done          (done),
  .cfg_err       (cfg_err),
  .peer_err      (peer_err),
  .ck_err_status (ck_err_status),
  .residual      (residual),
  .data_fire     (data_fire),
  .csum_fire     (csum_fire),
  .mismatch      (mismatch),
  .run_en        (run_en)
);

// File: tb/ckf_top_tb.sv
`timescale 1ns/1ps
module ckf_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        rx_mode = 1'b0;
  logic        ck_en = 1'b0;
  logic [3:0]  len_code = 4'b0;
  logic [15:0] byte_total = 16'd0;
  logic        s_valid = 1'b0;
  logic        s_ready;
  logic [7:0]  s_data = 8'h00;
  logic        m_valid;
  logic        m_ready = 1'b0;
  logic [7:0]  m_data;
  logic        busy, done, cfg_err, peer_err, ck_err_status;
  logic [15:0] residual;

  always #4 clk = ~clk;

  ckf_top u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .rx_mode(rx_mode), .ck_en(ck_en),
    .len_code(len_code), .byte_total(byte_total), .s_valid(s_valid),
    .s_ready(s_ready), .s_data(s_data), .m_valid(m_valid), .m_ready(m_ready),
    .m_data(m_data), .busy(busy), .done(done), .cfg_err(cfg_err),
    .peer_err(peer_err), .ck_err_status(ck_err_status), .residual(residual)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  bit seen_err = 1'b0;

  logic [7:0] dat  [0:127];
  logic [7:0] strm [0:127];

  // {rx, en, code[3:0], total[7:0], corrupt_index[3:0] (F = none), seed[7:0]}
  localparam logic [25:0] VEC [11] = '{
    {1'b0, 1'b1, 4'b0000, 8'd40, 4'hF, 8'h10},
    {1'b0, 1'b1, 4'b0001, 8'd32, 4'hF, 8'hF0},
    {1'b0, 1'b1, 4'b0011, 8'd20, 4'hF, 8'h33},
    {1'b0, 1'b1, 4'b0111, 8'd10, 4'hF, 8'h81},
    {1'b0, 1'b1, 4'b1111, 8'd6,  4'hF, 8'hC4},
    {1'b0, 1'b0, 4'b0101, 8'd12, 4'hF, 8'h22},
    {1'b1, 1'b1, 4'b0011, 8'd24, 4'hF, 8'h47},
    {1'b1, 1'b1, 4'b0111, 8'd14, 4'hF, 8'h99},
    {1'b1, 1'b1, 4'b0001, 8'd40, 4'h1, 8'h0E},
    {1'b1, 1'b1, 4'b1111, 8'd10, 4'h0, 8'h60},
    {1'b1, 1'b0, 4'b0000, 8'd16, 4'hF, 8'hA5}
  };

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic start_txn(input bit rx, input bit en, input logic [3:0] code, input int tot);
    @(negedge clk);
    rx_mode = rx; ck_en = en; len_code = code; byte_total = 16'(tot); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  function automatic int blen(input logic [3:0] code);
    case (code)
      4'b0000: return 32;
      4'b0001: return 16;
      4'b0011: return 8;
      4'b0111: return 4;
      4'b1111: return 2;
      default: return 0;
    endcase
  endfunction

  task automatic run_vec(input int v);
    logic [25:0] e;
    bit vrx, ven, hit, done_seen;
    logic [3:0] vcode;
    logic [7:0] vseed, acc, ck, exp_b, src_b;
    int vtot, vcor, n, k, cnum, pos, halt_after, in_idx, out_idx, cyc, src_len, exp_len;
    string req;
    e = VEC[v];
    vrx = e[25]; ven = e[24]; vcode = e[23:20]; vtot = int'(e[19:12]);
    vcor = int'(e[11:8]); vseed = e[7:0];
    n = blen(vcode);
    acc = 8'h00; k = 0; cnum = 0; pos = 0; halt_after = vtot; hit = 1'b0;
    for (int i = 0; i < vtot; i++) begin
      dat[i] = 8'(int'(vseed) + i * 37);
      strm[k] = dat[i]; k++;
      acc = acc + dat[i]; pos++;
      if (ven && (pos == n || i == vtot - 1)) begin
        ck = acc;
        if (vrx && cnum == vcor) begin
          ck = ck ^ 8'h5A;
          if (!hit) halt_after = i + 1;
          hit = 1'b1;
        end
        strm[k] = ck; k++;
        cnum++; acc = 8'h00; pos = 0;
      end
    end
    req = !ven ? "R1" : (!vrx ? ((vtot % n) != 0 ? "R4" : "R3") : (hit ? "R9" : "R7"));
    src_len = (vrx && ven) ? k : vtot;
    exp_len = (!vrx && ven) ? k : ((vrx && ven) ? halt_after : vtot);
    start_txn(vrx, ven, vcode, vtot);
    in_idx = 0; out_idx = 0; cyc = 0; done_seen = 1'b0;
    forever begin
      @(negedge clk);
      if (done || peer_err || cyc > 2000) begin
        done_seen = done;
        break;
      end
      cyc++;
      m_ready = ((cyc % 3) != 2);
      src_b = (vrx && ven) ? strm[in_idx] : dat[in_idx];
      s_valid = (in_idx < src_len) && ((cyc % 4) != 1);
      s_data = src_b;
      #1;
      if (s_valid && s_ready) in_idx++;
      if (m_valid && m_ready) begin
        exp_b = (!vrx && ven) ? strm[out_idx] : dat[out_idx];
        check(out_idx < exp_len && m_data == exp_b, req,
              $sformatf("vec %0d out byte %0d", v, out_idx), int'(m_data), int'(exp_b));
        out_idx++;
      end
    end
    s_valid = 1'b0;
    m_ready = 1'b0;
    if (hit) seen_err = 1'b1;
    check(out_idx == exp_len, req, $sformatf("vec %0d output byte count", v), out_idx, exp_len);
    check(done_seen == !hit, "R5", $sformatf("vec %0d done pulse", v), int'(done_seen), int'(!hit));
    check(peer_err == hit, "R8", $sformatf("vec %0d peer_err", v), int'(peer_err), int'(hit));
    check(ck_err_status == seen_err, "R8", $sformatf("vec %0d ck_err_status", v),
          int'(ck_err_status), int'(seen_err));
    check(int'(residual) == vtot - halt_after, "R9", $sformatf("vec %0d residual", v),
          int'(residual), vtot - halt_after);
    if (hit) begin
      @(negedge clk);
      s_valid = 1'b1; m_ready = 1'b1; s_data = 8'h77;
      #1;
      check(!s_ready, "R9", "s_ready after mismatch", int'(s_ready), 0);
      @(negedge clk);
      check(int'(residual) == vtot - halt_after, "R9", "residual held after stall",
            int'(residual), vtot - halt_after);
      s_valid = 1'b0; m_ready = 1'b0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    check(!busy && !done, "R10", "busy/done after reset", int'(busy || done), 0);
    check(!cfg_err && !peer_err && !ck_err_status, "R10", "error flags after reset",
          int'({cfg_err, peer_err, ck_err_status}), 0);
    check(residual == 16'd0, "R10", "residual after reset", int'(residual), 0);
    s_valid = 1'b1; m_ready = 1'b1;
    #1;
    check(!s_ready && !m_valid, "R10", "stream idle after reset", int'({s_ready, m_valid}), 0);
    s_valid = 1'b0; m_ready = 1'b0;

    // R6 invalid length code with checksum enabled
    start_txn(1'b0, 1'b1, 4'b0101, 8);
    check(cfg_err == 1'b1, "R6", "cfg_err for bad code", int'(cfg_err), 1);
    check(!busy, "R6", "busy after bad code", int'(busy), 0);
    s_valid = 1'b1; m_ready = 1'b1;
    #1;
    check(!s_ready && !m_valid, "R6", "no transfer after bad code", int'({s_ready, m_valid}), 0);
    s_valid = 1'b0; m_ready = 1'b0;

    // R6 odd byte count
    start_txn(1'b0, 1'b1, 4'b0011, 7);
    check(cfg_err == 1'b1 && !busy, "R6", "cfg_err for odd count", int'({cfg_err, busy}), 2);

    // R5 zero count completes at once; R6 flag rewritten by accepted start
    start_txn(1'b0, 1'b1, 4'b0011, 0);
    check(done == 1'b1, "R5", "done for zero count", int'(done), 1);
    check(!cfg_err && !busy, "R6", "cfg_err cleared by good start", int'({cfg_err, busy}), 0);
    @(negedge clk);
    check(!done, "R5", "done lasts one cycle", int'(done), 0);

    // Table walk: R1, R2, R3, R4, R7, R8, R9
    for (int v = 0; v < 11; v++) run_vec(v);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule